// File: doc/BRIEF.md
# Timekeeper Two-Wire Register Slave

This block is the serial front end of a timekeeping device. It listens on a two-wire bus, answers at one fixed device address, and gives the bus master access to a 20-byte register map. The map is ordered as follows:

| Offset | Content |
|---|---|
| 0 | fractional seconds |
| 1 | seconds |
| 2 | minutes |
| 3 | hours and century |
| 4 | weekday |
| 5 | day of month |
| 6 | month |
| 7 | year |
| 8 | control |
| 9 | watchdog |
| 10 to 15 | alarm |
| 16 to 18 | reserved gap |
| 19 | square-wave output control |

A write transfer sets a byte pointer and then stores bytes with auto-increment. A read transfer streams bytes from the pointer onward. A parallel local port lets the timekeeping logic read and update any byte.

A power-good input guards the bus side. When power-good is low, the slave drops any transfer, releases SDA and clears the pointer. It ignores both bus lines until power-good returns and a fresh start condition arrives.

The FSM has these states:
- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` acknowledges the address.
- `ST_WR_BYTE` and `ST_WR_ACK` take one write byte and acknowledge it.
- `ST_RD_BYTE` and `ST_RD_ACK` send one byte and sample the master's acknowledge.

The FSM has these transitions:
- A start moves from any state to `ST_ADDR`.
- A stop moves from any state to `ST_IDLE`.
- An address match moves `ST_ADDR` to `ST_ADDR_ACK`, and a mismatch moves it to `ST_IDLE`.
- `ST_ADDR_ACK` moves to `ST_WR_BYTE` or `ST_RD_BYTE`, chosen by the R/W bit.
- Each byte state moves to its ack state after the eighth bit.
- `ST_WR_ACK` moves back to `ST_WR_BYTE`.
- `ST_RD_ACK` moves to `ST_RD_BYTE` on a master ACK and to `ST_IDLE` on a NACK.
- Power-good low forces `ST_IDLE`.

Top module: `rtc_i2c_regbank`

## Requirements
- R1: The slave acknowledges only the address bytes D0h (write) and D1h (read), that is 7-bit address 68h. Any other address gets no acknowledge, and the transfer that follows writes nothing.
- R2: The first byte written after the address sets the pointer. A value of 20 or more sets it to 0. Each later write byte is acknowledged, stored at the pointer, and the pointer then steps by one.
- R3: In a read, the slave sends the byte at the pointer MSB first, and the pointer steps after each byte. The read continues while the master acknowledges, and a master NACK ends it.
- R4: The pointer steps from offset 19 to offset 0 and never holds a value above 19.
- R5: Offsets 16, 17 and 18 always read as zero on both ports, and writes to them from either port have no effect.
- R6: A repeated start is accepted without a stop. The pointer keeps its value across a repeated start and across a stop, so a read that does not set the pointer starts where the last access ended.
- R7: When pwr_ok goes low, SDA is released on the next clock, the transfer is abandoned and the pointer becomes 0.
- R8: While pwr_ok is low, no bus activity is acknowledged and no register changes from the bus. After pwr_ok returns, the slave ignores the bus until a new start condition.
- R9: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A stop ends the transfer at once, even inside a byte, and a partial byte is not stored.
- R10: After reset every byte reads 0. loc_rdata shows the byte at loc_addr combinationally, and a loc_we pulse stores loc_wdata at the next clock edge. A bus write in the same cycle takes priority.
- R11: The slave starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, at least 8 times the SCL rate |
| rst_n | input | 1 | active-low asynchronous reset |
| scl_i | input | 1 | bus clock line |
| sda_i | input | 1 | bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| pwr_ok | input | 1 | supply within tolerance; low blocks the bus side |
| loc_addr | input | 5 | local port byte offset |
| loc_we | input | 1 | local port write strobe |
| loc_wdata | input | 8 | local port write data |
| loc_rdata | output | 8 | local port read data |

## Verification
Assertions run on every cycle and check the following:
- SDA is released and the pointer is cleared in the cycle after power-good drops.
- No store happens without power.
- The pointer never leaves the 0 to 19 range.
- The reserved gap always reads zero.
- SDA drive only begins while SCL is low.

Some behaviour can only be shown by the bench's transfers:
- address filtering
- pointer loading with its clamp
- auto-increment across the wrap
- the byte order of reads
- pointer retention over repeated starts and stops
- a stop inside a byte
- ignoring bus traffic until a new start after power returns

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_now   = scl_pipe[STAGES-1];
    assign sda_now   = sda_pipe[STAGES-1];
    assign sda_lvl   = sda_now;

    // Edge and control-condition events, all masked while the supply is bad
    assign scl_rise  = enable &  scl_now & ~scl_prev;
    assign scl_fall  = enable & ~scl_now &  scl_prev;
    assign start_det = enable &  scl_now &  scl_prev &  sda_prev & ~sda_now;
    assign stop_det  = enable &  scl_now &  scl_prev & ~sda_prev &  sda_now;

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
    parameter int NUM_REGS   = 20,
    parameter int DW         = 8,
    parameter int AW         = 5,
    parameter int RSVD_FIRST = 16,
    parameter int RSVD_LAST  = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] loc_rdata
);

    localparam int FLAT_W = NUM_REGS * DW;

    logic [FLAT_W-1:0] cells;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        if (g >= RSVD_FIRST && g <= RSVD_LAST) begin : g_gap
            assign cells[g*DW +: DW] = '0;
        end else begin : g_store
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (bus_we && bus_addr == AW'(g)) begin
                    q <= bus_wdata;
                end else if (loc_we && loc_addr == AW'(g)) begin
                    q <= loc_wdata;
                end
            end
            assign cells[g*DW +: DW] = q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        loc_rdata = '0;
        if (bus_addr < AW'(NUM_REGS)) bus_rdata = cells[bus_addr*DW +: DW];
        if (loc_addr < AW'(NUM_REGS)) loc_rdata = cells[loc_addr*DW +: DW];
    end

endmodule

// File: rtl/rtc_i2c_fsm.sv
module rtc_i2c_fsm
    import rtc_i2c_pkg::*;
#(
    parameter int         DW       = 8,
    parameter int         AW       = 5,
    parameter int         NUM_REGS = 20,
    parameter logic [6:0] DEV_ADDR = 7'h68
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);

    localparam int            CW       = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW);

    slv_state_e    state_q, state_n;
    logic [DW-1:0] shreg_q, shreg_n;
    logic [CW-1:0] bitcnt_q, bitcnt_n;
    logic [AW-1:0] ptr_q, ptr_n;
    logic          rnw_q, rnw_n;
    logic          first_q, first_n;
    logic          mack_q, mack_n;
    logic          drive_n;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(NUM_REGS - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] load_ptr(input logic [DW-1:0] b);
        return (b < DW'(NUM_REGS)) ? b[AW-1:0] : '0;
    endfunction

    always_comb begin
        state_n  = state_q;
        shreg_n  = shreg_q;
        bitcnt_n = bitcnt_q;
        ptr_n    = ptr_q;
        rnw_n    = rnw_q;
        first_n  = first_q;
        mack_n   = mack_q;
        wr_en    = 1'b0;
        if (!pwr_ok) begin
            state_n  = ST_IDLE;
            ptr_n    = '0;
            bitcnt_n = '0;
        end else if (start_det) begin
            state_n  = ST_ADDR;
            bitcnt_n = '0;
        end else if (stop_det) begin
            state_n  = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_n  = {shreg_q[DW-2:0], sda_lvl};
                        bitcnt_n = bitcnt_q + 1'b1;
                    end else if (scl_fall && bitcnt_q == LAST_BIT) begin
                        if (shreg_q[DW-1:1] == DEV_ADDR) begin
                            state_n = ST_ADDR_ACK;
                            rnw_n   = shreg_q[0];
                            first_n = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt_n = '0;
                        if (rnw_q) begin
                            state_n = ST_RD_BYTE;
                            shreg_n = rd_data;
                        end else begin
                            state_n = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg_n  = {shreg_q[DW-2:0], sda_lvl};
                        bitcnt_n = bitcnt_q + 1'b1;
                    end else if (scl_fall && bitcnt_q == LAST_BIT) begin
                        state_n = ST_WR_ACK;
                        if (first_q) begin
                            ptr_n   = load_ptr(shreg_q);
                            first_n = 1'b0;
                        end else begin
                            wr_en = 1'b1;
                            ptr_n = step_ptr(ptr_q);
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        state_n  = ST_WR_BYTE;
                        bitcnt_n = '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        bitcnt_n = bitcnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt_q == LAST_BIT) begin
                            state_n = ST_RD_ACK;
                            ptr_n   = step_ptr(ptr_q);
                        end else begin
                            shreg_n = {shreg_q[DW-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_n = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_n  = ST_RD_BYTE;
                            shreg_n  = rd_data;
                            bitcnt_n = '0;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_n)
            ST_ADDR_ACK, ST_WR_ACK: drive_n = 1'b1;
            ST_RD_BYTE:             drive_n = ~shreg_n[DW-1];
            default:                drive_n = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            ptr_q    <= '0;
            rnw_q    <= 1'b0;
            first_q  <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            shreg_q  <= shreg_n;
            bitcnt_q <= bitcnt_n;
            ptr_q    <= ptr_n;
            rnw_q    <= rnw_n;
            first_q  <= first_n;
            mack_q   <= mack_n;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_oe <= 1'b0;
        else        sda_oe <= drive_n;
    end

    assign ptr     = ptr_q;
    assign wr_data = shreg_q;

endmodule

// File: rtl/rtc_i2c_regbank.sv
module rtc_i2c_regbank #(
    parameter int         NUM_REGS    = 20,
    parameter int         DW          = 8,
    parameter int         RSVD_FIRST  = 16,
    parameter int         RSVD_LAST   = 18,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h68
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe,
    input  logic                        pwr_ok,
    input  logic [$clog2(NUM_REGS)-1:0] loc_addr,
    input  logic                        loc_we,
    input  logic [DW-1:0]               loc_wdata,
    output logic [DW-1:0]               loc_rdata
);

    localparam int AW = $clog2(NUM_REGS);

    logic          sda_lvl;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic [AW-1:0] bus_ptr;
    logic          bus_we;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (pwr_ok),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rtc_i2c_fsm #(
        .DW       (DW),
        .AW       (AW),
        .NUM_REGS (NUM_REGS),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (bus_rdata),
        .sda_oe    (sda_oe),
        .ptr       (bus_ptr),
        .wr_en     (bus_we),
        .wr_data   (bus_wdata)
    );

    rtc_regfile #(
        .NUM_REGS   (NUM_REGS),
        .DW         (DW),
        .AW         (AW),
        .RSVD_FIRST (RSVD_FIRST),
        .RSVD_LAST  (RSVD_LAST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_ptr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .loc_we    (loc_we),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

endmodule

// File: rtl/rtc_i2c_checker.sv
module rtc_i2c_checker #(
    parameter int NUM_REGS   = 20,
    parameter int DW         = 8,
    parameter int AW         = 5,
    parameter int RSVD_FIRST = 16,
    parameter int RSVD_LAST  = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_ok,
    input logic          scl_i,
    input logic          sda_oe,
    input logic [AW-1:0] ptr,
    input logic          wr_en,
    input logic [AW-1:0] loc_addr,
    input logic [DW-1:0] loc_rdata
);

    assert_release_on_powerfail_R7: assert property (
        @(posedge clk) disable iff (!rst_n) !pwr_ok |=> !sda_oe);

    assert_ptr_cleared_on_powerfail_R7: assert property (
        @(posedge clk) disable iff (!rst_n) !pwr_ok |=> ptr == '0);

    assert_no_store_unpowered_R8: assert property (
        @(posedge clk) disable iff (!rst_n) wr_en |-> pwr_ok);

    assert_ptr_in_range_R4: assert property (
        @(posedge clk) disable iff (!rst_n) ptr < AW'(NUM_REGS));

    assert_gap_reads_zero_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (loc_addr >= AW'(RSVD_FIRST) && loc_addr <= AW'(RSVD_LAST)) |-> loc_rdata == '0);

    assert_drive_starts_scl_low_R11: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_i);

endmodule

bind rtc_i2c_regbank rtc_i2c_checker #(
    .NUM_REGS   (NUM_REGS),
    .DW         (DW),
    .AW         (AW),
    .RSVD_FIRST (RSVD_FIRST),
    .RSVD_LAST  (RSVD_LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .ptr       (bus_ptr),
    .wr_en     (bus_we),
    .loc_addr  (loc_addr),
    .loc_rdata (loc_rdata)
);

// File: tb/sim_rtc_i2c_regbank.sv
module sim_rtc_i2c_regbank;

    localparam int NREG = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_scl;
    logic       m_sda;
    logic       pwr_ok;
    logic       sda_oe;
    logic [4:0] loc_addr;
    logic       loc_we;
    logic [7:0] loc_wdata;
    logic [7:0] loc_rdata;
    wire        sda_line = m_sda & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int model [NREG];
    int mptr = 0;
    int r11_bad = 0;
    logic prev_oe = 1'b0;
    logic [7:0] wbuf [8];

    always #2 clk = ~clk;

    rtc_i2c_regbank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .pwr_ok    (pwr_ok),
        .loc_addr  (loc_addr),
        .loc_we    (loc_we),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

    // R11 monitor: drive must not begin while SCL is high
    always @(negedge clk) begin
        if (sda_oe && !prev_oe && m_scl) r11_bad++;
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int step(input int p);
        return (p == NREG - 1) ? 0 : p + 1;
    endfunction

    function automatic bit in_gap(input int a);
        return a >= 16 && a <= 18;
    endfunction

    function automatic int exp_byte(input int a);
        return in_gap(a) ? 0 : model[a];
    endfunction

    task automatic start_cond();
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(4);
        m_sda = 1'b0; tick(4);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic stop_cond();
        m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(4);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            m_sda = b[i]; tick(4);
            m_scl = 1'b1; tick(8);
            m_scl = 1'b0; tick(4);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(4);
        acked = (sda_line == 1'b0);
        tick(4);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(4);
            m_scl = 1'b1; tick(4);
            b[i] = sda_line;
            tick(4);
            m_scl = 1'b0; tick(4);
        end
        m_sda = ack ? 1'b0 : 1'b1; tick(4);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic do_write(input int p, input int n);
        bit a;
        start_cond();
        send_byte(8'hD0, a);
        check_eq("R1", "write address ack", int'(a), 1);
        send_byte(8'(p), a);
        check_eq("R2", "pointer byte ack", int'(a), 1);
        mptr = (p >= NREG) ? 0 : p;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            check_eq("R2", "data byte ack", int'(a), 1);
            if (!in_gap(mptr)) model[mptr] = int'(wbuf[k]);
            mptr = step(mptr);
        end
        stop_cond();
        check_eq("R9", "released after stop", int'(sda_oe), 0);
    endtask

    task automatic do_read(input int p, input int n, input bit set_ptr);
        bit a;
        logic [7:0] b;
        start_cond();
        if (set_ptr) begin
            send_byte(8'hD0, a);
            check_eq("R1", "write address ack", int'(a), 1);
            send_byte(8'(p), a);
            check_eq("R2", "pointer byte ack", int'(a), 1);
            mptr = (p >= NREG) ? 0 : p;
            start_cond();
        end
        send_byte(8'hD1, a);
        check_eq("R1", "read address ack", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            if (set_ptr) check_eq("R3 R6", $sformatf("read byte at %0d", mptr), int'(b), exp_byte(mptr));
            else         check_eq("R6 R3", $sformatf("current read at %0d", mptr), int'(b), exp_byte(mptr));
            mptr = step(mptr);
        end
        stop_cond();
    endtask

    task automatic check_all_loc(input string tag);
        for (int a = 0; a < NREG; a++) begin
            loc_addr = 5'(a);
            tick(1);
            check_eq(tag, $sformatf("local read offset %0d", a), int'(loc_rdata), exp_byte(a));
        end
    endtask

    task automatic loc_write(input int a, input logic [7:0] d);
        loc_addr = 5'(a); loc_wdata = d; loc_we = 1'b1;
        tick(1);
        loc_we = 1'b0;
        if (!in_gap(a)) model[a] = int'(d);
    endtask

    initial begin : main
        bit a;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) model[i] = 0;
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; pwr_ok = 1'b1;
        loc_we = 1'b0; loc_addr = '0; loc_wdata = '0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R10 reset state
        check_eq("R10", "sda_oe after reset", int'(sda_oe), 0);
        check_all_loc("R10");

        // R2 pointer then data
        wbuf[0] = 8'h59; wbuf[1] = 8'h30; wbuf[2] = 8'h12;
        do_write(2, 3);
        check_all_loc("R2");

        // R3 read back with repeated start, R6 current-address read
        do_read(2, 3, 1'b1);
        do_read(0, 2, 1'b0);

        // R1 wrong address gets no ack and writes nothing
        start_cond();
        send_byte(8'hA0, a);
        check_eq("R1", "foreign address nack", int'(a), 0);
        send_byte(8'h03, a);
        check_eq("R1", "byte after foreign address", int'(a), 0);
        send_byte(8'hEE, a);
        stop_cond();
        start_cond();
        send_byte(8'hD2, a);
        check_eq("R1", "near-miss address nack", int'(a), 0);
        stop_cond();
        check_all_loc("R1");
        do_read(0, 1, 1'b0);

        // R4 wrap and R5 gap via bus
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
        do_write(17, 4);
        check_all_loc("R5");
        do_read(18, 4, 1'b1);
        check_eq("R4", "pointer after wrap read", mptr, 2);

        // R2 pointer clamp
        wbuf[0] = 8'h6B;
        do_write(25, 1);
        check_eq("R2", "clamped pointer write at 0", model[0], 8'h6B);
        check_all_loc("R2");

        // R5 gap via local port, R10 local write then bus read
        loc_write(16, 8'hAA);
        loc_addr = 5'd16; tick(1);
        check_eq("R5", "gap after local write", int'(loc_rdata), 0);
        loc_write(9, 8'h3C);
        loc_addr = 5'd9; tick(1);
        check_eq("R10", "local write readback", int'(loc_rdata), 8'h3C);
        do_read(9, 1, 1'b1);

        // R9 stop inside a byte
        start_cond();
        send_byte(8'hD0, a);
        send_byte(8'h04, a);
        mptr = 4;
        send_bits(8'hF0, 4);
        stop_cond();
        check_all_loc("R9");
        do_read(0, 1, 1'b0);

        // R7 / R8 power failure during an ack
        start_cond();
        send_byte(8'hD0, a);
        send_bits(8'h0A, 8);
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(2);
        check_eq("R2", "ack before power loss", int'(sda_line), 0);
        pwr_ok = 1'b0;
        tick(2);
        check_eq("R7", "release on power loss", int'(sda_oe), 0);
        tick(4);
        m_scl = 1'b0; tick(4);
        send_byte(8'h77, a);
        check_eq("R8", "no ack while unpowered", int'(a), 0);
        stop_cond();
        start_cond();
        send_byte(8'hD0, a);
        check_eq("R8", "address ignored while unpowered", int'(a), 0);
        send_byte(8'h03, a);
        pwr_ok = 1'b1;
        tick(4);
        send_byte(8'hD0, a);
        check_eq("R8", "no ack before new start", int'(a), 0);
        send_byte(8'h55, a);
        check_eq("R8", "data ignored before new start", int'(a), 0);
        stop_cond();
        mptr = 0;
        check_all_loc("R8");
        do_read(0, 2, 1'b0);

        // Constrained random traffic
        for (int it = 0; it < 40; it++) begin
            int kind, p, n;
            kind = int'($urandom % 3);
            p    = int'($urandom % 24);
            n    = 1 + int'($urandom % 6);
            for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
            if (kind == 0)      do_write(p, n);
            else if (kind == 1) do_read(p, n, 1'b1);
            else                do_read(0, n, 1'b0);
        end
        check_all_loc("R2");

        check_eq("R11", "drive began while SCL high", r11_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule